// File: doc/BRIEF.md
# Multi-source acquisition trigger unit

This block decides when a four-channel sampling front end starts an acquisition. It runs entirely in the sampling clock domain and merges four kinds of trigger sources into one single-cycle pulse. The first kind is a threshold detector on each channel's signed raw sample. The second is an asynchronous external trigger pin. The third is a software strobe, and the fourth is a timed trigger pulse that is already synchronous to the sampling clock. Each source has its own enable.

Each channel detector compares the sample with a signed threshold on a selectable slope. Once it has fired, it stays disarmed until the sample moves back past the threshold by more than a signed hysteresis margin. The external trigger and each channel trigger pass through separate programmable delay counters, counted in sampling clock cycles. That lets the acquisition point be moved independently for each source. The software and timed triggers go straight to the output register.

Top module: `acq_trig_unit`

## Requirements
- R1: While reset is held, and in the cycles after it is released, `trig_o` is 0. All channel detectors come out of reset armed and all delay counters come out of reset idle.
- R2: With slope bit 0, an armed channel fires when its sample is greater than or equal to its threshold. With that channel's delay at 0, `trig_o` is high for one cycle, 2 cycles after the cycle the sample was presented.
- R3: After a rising-slope fire, the channel does not fire again until its sample has been strictly below threshold minus hysteresis for at least one cycle. A sample equal to threshold minus hysteresis does not re-arm it.
- R4: With slope bit 1, an armed channel fires when its sample is less than or equal to its threshold. It re-arms only when the sample is strictly above threshold plus hysteresis.
- R5: Samples, thresholds and hysteresis values are two's complement numbers of SAMPLE_W bits. Comparisons are signed and are computed without overflow.
- R6: A channel delay of N places the pulse on `trig_o` 2+N cycles after the firing sample. Each channel uses its own delay, independently of the other channels.
- R7: While a delay counter is running, a new trigger on the same source is ignored. The source produces exactly one output pulse per counter run.
- R8: The external input passes through a two-flop synchroniser and a rising-edge detector. A rise first seen in cycle k gives `trig_o` in cycle k+4+N, where N is the external delay. A level held high gives only one pulse.
- R9: A software strobe `sw_wr_i` in cycle t, with `sw_en_i` high, gives `trig_o` in cycle t+1.
- R10: A timed trigger pulse in cycle t, with `time_en_i` high, gives `trig_o` in cycle t+1.
- R11: A source whose enable bit is 0 produces no pulse on `trig_o`.
- R12: Sources that coincide in the same cycle produce a single one-cycle pulse, not a longer one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| samples_i | input | NCH*SAMPLE_W | Raw signed samples, channel c at bits [c*SAMPLE_W +: SAMPLE_W] |
| thresh_i | input | NCH*SAMPLE_W | Signed threshold per channel |
| hyst_i | input | NCH*SAMPLE_W | Signed hysteresis per channel |
| slope_i | input | NCH | Slope per channel: 0 rising, 1 falling |
| ch_dly_i | input | NCH*DLY_W | Delay per channel, in cycles |
| int_en_i | input | NCH | Enable per channel for its threshold trigger |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| ext_en_i | input | 1 | External trigger enable |
| ext_dly_i | input | DLY_W | External trigger delay, in cycles |
| sw_wr_i | input | 1 | Software trigger write strobe |
| sw_en_i | input | 1 | Software trigger enable |
| time_trig_i | input | 1 | Synchronous timed trigger pulse |
| time_en_i | input | 1 | Timed trigger enable |
| trig_o | output | 1 | Merged acquisition trigger pulse |

## Verification
The assertions assume three things about the inputs. The software strobe and the timed pulse are synchronous to the sampling clock. The delay values stay stable while their counter runs. The hysteresis value is non-negative, so the re-arm level lies on the far side of the threshold. The stimulus changes inputs only just after a clock edge. It holds each delay setting constant across a whole trigger window and uses only positive hysteresis margins. The external pin is driven as a held level, so the edge detector sees a clean rise.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

    typedef enum logic {
        SLOPE_RISE = 1'b0,
        SLOPE_FALL = 1'b1
    } slope_e;

    typedef enum logic {
        DLY_IDLE = 1'b0,
        DLY_RUN  = 1'b1
    } dly_state_e;

    // Sign-extend a W-bit value into W+2 bits so that threshold +/- hysteresis cannot overflow
    function automatic logic signed [17:0] widen16(input logic signed [15:0] v);
        return 18'(v);
    endfunction

endpackage

// File: rtl/acq_thresh_det.sv
module acq_thresh_det
    import acq_trig_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic signed [SAMPLE_W-1:0] thresh_i,
    input  logic signed [SAMPLE_W-1:0] hyst_i,
    input  logic                       slope_i,
    output logic                       hit_o
);
    localparam int XW = SAMPLE_W + 2;

    logic signed [XW-1:0] s_x, t_x, h_x, lo_lim, hi_lim;
    logic armed, crossed, rearm;
    slope_e slope;

    always_comb begin
        slope  = slope_e'(slope_i);
        s_x    = XW'(sample_i);
        t_x    = XW'(thresh_i);
        h_x    = XW'(hyst_i);
        lo_lim = t_x - h_x;
        hi_lim = t_x + h_x;
        if (slope == SLOPE_RISE) begin
            crossed = (s_x >= t_x);
            rearm   = (s_x <  lo_lim);
        end else begin
            crossed = (s_x <= t_x);
            rearm   = (s_x >  hi_lim);
        end
        hit_o = armed && crossed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
        end else if (hit_o) begin
            armed <= 1'b0;
        end else if (!armed && rearm) begin
            armed <= 1'b1;
        end
    end

    // R3/R4: a fire always disarms, so two fires in a row are impossible
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> !hit_o);

    // R3: a disarmed rising detector that has not seen the re-arm level stays silent
    a_r3_hold_disarmed: assert property (@(posedge clk) disable iff (rst)
        (!armed && !rearm && !hit_o) |=> !hit_o);

endmodule

// File: rtl/acq_trig_delay.sv
module acq_trig_delay
    import acq_trig_pkg::*;
#(
    parameter int DLY_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             pulse_o
);
    dly_state_e       st;
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= DLY_IDLE;
            cnt     <= '0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= 1'b0;
            unique case (st)
                DLY_IDLE: begin
                    if (pulse_i) begin
                        if (dly_i == '0) begin
                            pulse_o <= 1'b1;
                        end else begin
                            st  <= DLY_RUN;
                            cnt <= dly_i;
                        end
                    end
                end
                DLY_RUN: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == DLY_W'(1)) begin
                        st      <= DLY_IDLE;
                        pulse_o <= 1'b1;
                    end
                end
                default: st <= DLY_IDLE;
            endcase
        end
    end

    // R6: zero delay is a single register stage
    a_r6_zero_passthru: assert property (@(posedge clk) disable iff (rst)
        (pulse_i && st == DLY_IDLE && dly_i == '0) |=> pulse_o);

    // R7: a running counter never holds zero
    a_r7_run_nonzero: assert property (@(posedge clk) disable iff (rst)
        (st == DLY_RUN) |-> (cnt != '0));

    // R7: no output until the count reaches its last step, whatever arrives on the input
    a_r7_quiet_while_running: assert property (@(posedge clk) disable iff (rst)
        (st == DLY_RUN && cnt > DLY_W'(1)) |=> !pulse_o);

endmodule

// File: rtl/acq_ext_sync.sv
module acq_ext_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[1:0], async_i};
        end
    end

    assign rise_o = sh[1] & ~sh[2];

    // R8: an edge is reported for exactly one cycle
    a_r8_single_edge: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/acq_trig_unit.sv
module acq_trig_unit
    import acq_trig_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int SAMPLE_W = 16,
    parameter int DLY_W    = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCH*SAMPLE_W-1:0] samples_i,
    input  logic [NCH*SAMPLE_W-1:0] thresh_i,
    input  logic [NCH*SAMPLE_W-1:0] hyst_i,
    input  logic [NCH-1:0]          slope_i,
    input  logic [NCH*DLY_W-1:0]    ch_dly_i,
    input  logic [NCH-1:0]          int_en_i,
    input  logic                    ext_trig_i,
    input  logic                    ext_en_i,
    input  logic [DLY_W-1:0]        ext_dly_i,
    input  logic                    sw_wr_i,
    input  logic                    sw_en_i,
    input  logic                    time_trig_i,
    input  logic                    time_en_i,
    output logic                    trig_o
);
    logic [NCH-1:0] ch_hit, ch_delayed;
    logic           ext_rise, ext_delayed;
    logic           trig_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic gated;

        acq_thresh_det #(.SAMPLE_W(SAMPLE_W)) u_det (
            .clk      (clk),
            .rst      (rst),
            .sample_i (samples_i[c*SAMPLE_W +: SAMPLE_W]),
            .thresh_i (thresh_i[c*SAMPLE_W +: SAMPLE_W]),
            .hyst_i   (hyst_i[c*SAMPLE_W +: SAMPLE_W]),
            .slope_i  (slope_i[c]),
            .hit_o    (ch_hit[c])
        );

        assign gated = ch_hit[c] & int_en_i[c];

        acq_trig_delay #(.DLY_W(DLY_W)) u_dly (
            .clk     (clk),
            .rst     (rst),
            .pulse_i (gated),
            .dly_i   (ch_dly_i[c*DLY_W +: DLY_W]),
            .pulse_o (ch_delayed[c])
        );
    end

    acq_ext_sync u_ext_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ext_trig_i),
        .rise_o  (ext_rise)
    );

    acq_trig_delay #(.DLY_W(DLY_W)) u_ext_dly (
        .clk     (clk),
        .rst     (rst),
        .pulse_i (ext_rise & ext_en_i),
        .dly_i   (ext_dly_i),
        .pulse_o (ext_delayed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= (|ch_delayed) | ext_delayed
                    | (sw_wr_i & sw_en_i) | (time_trig_i & time_en_i);
        end
    end

    assign trig_o = trig_q;

    // R9: an enabled software strobe reaches the output one cycle later
    a_r9_sw_next: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_i && sw_en_i) |=> trig_o);

    // R10: an enabled timed pulse reaches the output one cycle later
    a_r10_time_next: assert property (@(posedge clk) disable iff (rst)
        (time_trig_i && time_en_i) |=> trig_o);

    // R1: the output register is clear in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !trig_o);

endmodule

// File: tb/acq_trig_unit_tb.sv
module acq_trig_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int SW  = 16;
    localparam int DW  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [SW-1:0] smp [NCH];
    logic signed [SW-1:0] thr [NCH];
    logic signed [SW-1:0] hys [NCH];
    logic [DW-1:0] cdly [NCH];
    logic [NCH*SW-1:0] samples_f, thresh_f, hyst_f;
    logic [NCH*DW-1:0] dly_f;
    logic [NCH-1:0] slope, int_en;
    logic ext_trig, ext_en, sw_wr, sw_en, time_trig, time_en;
    logic [DW-1:0] ext_dly;
    logic trig_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            samples_f[c*SW +: SW] = smp[c];
            thresh_f[c*SW +: SW]  = thr[c];
            hyst_f[c*SW +: SW]    = hys[c];
            dly_f[c*DW +: DW]     = cdly[c];
        end
    end

    acq_trig_unit #(.NCH(NCH), .SAMPLE_W(SW), .DLY_W(DW)) u_dut (
        .clk(clk), .rst(rst), .samples_i(samples_f), .thresh_i(thresh_f),
        .hyst_i(hyst_f), .slope_i(slope), .ch_dly_i(dly_f), .int_en_i(int_en),
        .ext_trig_i(ext_trig), .ext_en_i(ext_en), .ext_dly_i(ext_dly),
        .sw_wr_i(sw_wr), .sw_en_i(sw_en), .time_trig_i(time_trig),
        .time_en_i(time_en), .trig_o(trig_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Stimulus is applied in cycle 0; observe cycles 1..len. Strobes are cleared after cycle 0.
    task automatic window(input int len, output int first, output int count);
        first = -1;
        count = 0;
        for (int i = 1; i <= len; i++) begin
            step();
            sw_wr = 1'b0;
            time_trig = 1'b0;
            if (trig_o) begin
                count++;
                if (first < 0) first = i;
            end
        end
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int first, count;
        for (int c = 0; c < NCH; c++) begin
            smp[c] = 16'sd0; thr[c] = 16'sd1000; hys[c] = 16'sd50; cdly[c] = '0;
        end
        slope = '0; int_en = '0; ext_trig = 0; ext_en = 0; sw_wr = 0; sw_en = 0;
        time_trig = 0; time_en = 0; ext_dly = '0;
        settle(3);
        check("R1 trig_o during reset", int'(trig_o), 0);
        rst = 1'b0;
        window(5, first, count);
        check("R1 quiet after reset", count, 0);

        // R2, R6: sweep every channel over delays 0..5, firing exactly at threshold
        for (int c = 0; c < NCH; c++) begin
            for (int n = 0; n < 6; n++) begin
                int_en = '0; int_en[c] = 1'b1; cdly[c] = DW'(n);
                smp[c] = 16'sd1000;
                window(12, first, count);
                check($sformatf("R2/R6 ch%0d dly%0d latency", c, n), first, 2 + n);
                check($sformatf("R2 ch%0d dly%0d count", c, n), count, 1);
                smp[c] = 16'sd949;
                settle(2);
            end
            cdly[c] = '0;
        end

        // R3: re-arm level is strict
        int_en = 4'b0001;
        smp[0] = 16'sd1000; window(4, first, count);
        check("R3 first fire", first, 2);
        smp[0] = 16'sd950; settle(2);
        smp[0] = 16'sd1000; window(6, first, count);
        check("R3 no re-arm at thr-hyst", count, 0);
        smp[0] = 16'sd949; settle(1);
        smp[0] = 16'sd1000; window(6, first, count);
        check("R3 re-arm below thr-hyst", first, 2);
        smp[0] = 16'sd0; settle(2);

        // R4, R5: falling slope on negative threshold
        int_en = 4'b0010; slope = 4'b0010; thr[1] = -16'sd200; hys[1] = 16'sd30;
        smp[1] = 16'sd0; settle(2);
        smp[1] = -16'sd200; window(6, first, count);
        check("R4 falling fire", first, 2);
        smp[1] = -16'sd170; settle(2);
        smp[1] = -16'sd200; window(6, first, count);
        check("R4 no re-arm at thr+hyst", count, 0);
        smp[1] = -16'sd169; settle(1);
        smp[1] = -16'sd250; window(6, first, count);
        check("R4 re-arm above thr+hyst", first, 2);
        smp[1] = 16'sd0; settle(2); slope = '0;

        // R5: signed compare on rising slope
        int_en = 4'b0100; thr[2] = -16'sd5; hys[2] = 16'sd10;
        smp[2] = -16'sd32768; settle(2);
        smp[2] = -16'sd6; window(6, first, count);
        check("R5 -6 below -5 no fire", count, 0);
        smp[2] = -16'sd5; window(6, first, count);
        check("R5 -5 reaches -5", first, 2);
        smp[2] = 16'sd32767; window(4, first, count);
        check("R5 max positive no refire", count, 0);
        smp[2] = -16'sd32768; settle(2);

        // R7: retrigger during a running count is ignored
        int_en = 4'b0100; cdly[2] = DW'(5);
        smp[2] = -16'sd5; step(); first = -1; count = 0;
        smp[2] = -16'sd100; step(); if (trig_o) count++;
        smp[2] = -16'sd5;
        for (int i = 3; i <= 15; i++) begin
            step();
            if (trig_o) begin count++; if (first < 0) first = i; end
        end
        check("R7 single pulse", count, 1);
        check("R7 latency kept", first, 7);
        smp[2] = -16'sd100; settle(2); cdly[2] = '0;

        // R6: independent delays on two channels firing together
        int_en = 4'b1001; cdly[0] = DW'(2); cdly[3] = DW'(5);
        smp[0] = 16'sd1000; smp[3] = 16'sd1000;
        window(12, first, count);
        check("R6 earliest channel", first, 4);
        check("R6 two pulses", count, 2);
        smp[0] = 16'sd0; smp[3] = 16'sd0; cdly[0] = '0; cdly[3] = '0; settle(2);
        int_en = '0;

        // R8: external sweep, level held high
        ext_en = 1'b1;
        for (int n = 0; n < 6; n++) begin
            ext_dly = DW'(n); ext_trig = 1'b1;
            window(14, first, count);
            check($sformatf("R8 ext dly%0d latency", n), first, 4 + n);
            check($sformatf("R8 ext dly%0d count", n), count, 1);
            ext_trig = 1'b0; settle(4);
        end

        // R9, R10
        sw_en = 1'b1; sw_wr = 1'b1; window(4, first, count);
        check("R9 sw latency", first, 1);
        check("R9 sw count", count, 1);
        time_en = 1'b1; time_trig = 1'b1; window(4, first, count);
        check("R10 time latency", first, 1);
        check("R10 time count", count, 1);

        // R12: coincident sources give one pulse
        sw_wr = 1'b1; time_trig = 1'b1; window(4, first, count);
        check("R12 coincident single", count, 1);

        // R11: disabled sources are silent
        sw_en = 1'b0; time_en = 1'b0; ext_en = 1'b0; int_en = '0;
        sw_wr = 1'b1; window(4, first, count);
        check("R11 sw disabled", count, 0);
        time_trig = 1'b1; window(4, first, count);
        check("R11 time disabled", count, 0);
        ext_dly = '0; ext_trig = 1'b1; window(10, first, count);
        check("R11 ext disabled", count, 0);
        ext_trig = 1'b0;
        smp[0] = 16'sd1000; window(6, first, count);
        check("R11 channel disabled", count, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule